// File: doc/BRIEF.md
# Row Skip and Pixel Averaging Decimator

This block shrinks a pixel stream in two directions at once. Rows are dropped by a per-frame row index and a two-bit skip code. Pixels are merged inside each kept row by a two-bit averaging code. The input is a frame-start pulse, a line-valid level that is high while a row's pixels arrive (one pixel per clock), and the pixel word. The output is a regenerated line-valid that is high only for kept rows, plus a strobe and data word for each finished average.

A raw-mode input selects Bayer-aware behaviour. In raw mode the skip patterns keep rows in adjacent pairs, so every surviving row pair still holds both colour phases. Averaging in raw mode combines same-colour samples, which lie two pixels apart, and emits the two colour lanes in their original alternating order. Outside raw mode the stream is treated as YUV/RGB: single rows are kept, and consecutive pixels are averaged.

The skip, averaging and raw-mode settings are expected to stay stable for the whole of a frame.

Top module: `pix_decim`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, `line_valid_o` and `pix_valid_o` are 0.
- R2: With skip code 00, every row is kept, and `line_valid_o` repeats `line_valid_i` one clock later.
- R3: With skip code 01 and `raw_mode_i`=0, only rows whose index within the frame is even are kept.
- R4: With skip code 01 and `raw_mode_i`=1, only rows with index mod 4 equal to 0 or 1 are kept.
- R5: With skip code 10 or 11 and `raw_mode_i`=0, only rows with index mod 4 equal to 0 are kept.
- R6: With skip code 10 or 11 and `raw_mode_i`=1, only rows with index mod 8 equal to 0 or 1 are kept.
- R7: A dropped row raises neither `line_valid_o` nor `pix_valid_o`.
- R8: A `frame_start_i` pulse sets the row index to 0, so the next row is row 0. Rows are counted at each falling edge of `line_valid_i`.
- R9: With averaging code 00 or 10, every pixel of a kept row is output unchanged, one clock after it enters.
- R10: With `raw_mode_i`=0, averaging code 01 outputs the truncated mean of each consecutive pixel pair, and code 11 outputs the truncated mean of each consecutive group of four. Groups start at the first pixel of the row.
- R11: With `raw_mode_i`=1, averaging code 01 or 11 averages 2 or 4 same-colour samples taken every second pixel. Within each block of 2N pixels, the even-position result is emitted first and the odd-position result second, each one clock after its last sample.
- R12: A group that is incomplete when `line_valid_i` falls produces no output and does not carry into the next row.
- R13: `pix_valid_o` is high only in cycles where `line_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start_i | input | 1 | One-cycle pulse before the first row of a frame |
| line_valid_i | input | 1 | High while a row's pixels arrive, one per clock |
| pix_i | input | DW | Input pixel |
| raw_mode_i | input | 1 | 1 = Bayer raw data, 0 = YUV/RGB |
| skip_code_i | input | 2 | Row skip selection |
| avg_code_i | input | 2 | Horizontal averaging selection |
| line_valid_o | output | 1 | Regenerated line-valid for kept rows |
| pix_valid_o | output | 1 | Strobe for one output pixel |
| pix_o | output | DW | Output pixel |

## Verification
Each of the six skip pattern and data format pairings is run over eight consecutive rows. Together these runs separate a single-row pattern from a paired-row one, and a period of four from a period of eight. A frame-start pulse sent partway through a frame shows that the skip phase realigns to row 0. The averaging runs use unaligned pixel values, including a pair of full-scale values, which exposes truncation. Raw-mode runs separate same-colour pairing from neighbour pairing. Row lengths that are not multiples of the group size show that leftover samples are dropped and do not leak into the next row.

// File: rtl/pdec_pkg.sv
package pdec_pkg;

    // Row index bits needed by the longest skip period (8 rows)
    localparam int ROW_W = 3;

    // Averaging code to log2 of the group size
    function automatic logic [1:0] avg_shift(input logic [1:0] code);
        logic [1:0] s;
        if (!code[0])       s = 2'd0;
        else if (!code[1])  s = 2'd1;
        else                s = 2'd2;
        return s;
    endfunction

    // Row keep decision from the format, the skip code and the row index
    function automatic logic row_kept(input logic raw,
                                      input logic [1:0] skip,
                                      input logic [ROW_W-1:0] row);
        logic k;
        unique case (skip)
            2'b00:   k = 1'b1;
            2'b01:   k = raw ? (row[1] == 1'b0) : (row[0] == 1'b0);
            default: k = raw ? (row[2:1] == 2'b00) : (row[1:0] == 2'b00);
        endcase
        return k;
    endfunction

endpackage

// File: rtl/pdec_row_gate.sv
module pdec_row_gate
    import pdec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start_i,
    input  logic       line_valid_i,
    input  logic       raw_mode_i,
    input  logic [1:0] skip_code_i,
    output logic       keep_o
);

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic             lv;
    } rg_state_t;

    rg_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.lv = line_valid_i;
        if (frame_start_i)
            st_d.row = '0;
        else if (st_q.lv && !line_valid_i)
            st_d.row = st_q.row + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign keep_o = row_kept(raw_mode_i, skip_code_i, st_q.row);

    // After a frame-start pulse the next row is row 0
    assert_row_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_i |=> (st_q.row == '0));

endmodule

// File: rtl/pdec_hsum.sv
module pdec_hsum
    import pdec_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_valid_i,
    input  logic          en_i,
    input  logic [DW-1:0] pix_i,
    input  logic          raw_i,
    input  logic [1:0]    avg_code_i,
    output logic          vld_o,
    output logic [DW-1:0] pix_o
);

    localparam int MAX_SH = 2;
    localparam int ACC_W  = DW + MAX_SH;
    localparam int PC_W   = MAX_SH + 1;
    localparam int LANES  = 2;

    typedef struct packed {
        logic [LANES-1:0][ACC_W-1:0] acc;
        logic [PC_W-1:0]             pc;
        logic                        vld;
        logic [DW-1:0]               pix;
    } hs_state_t;

    hs_state_t st_d, st_q;

    logic [1:0]       shift;
    logic [1:0]       last_pos;
    logic [1:0]       pos;
    logic [PC_W-1:0]  span_m1;
    logic             lane;
    logic [ACC_W-1:0] sum;

    always_comb begin
        shift    = avg_shift(avg_code_i);
        last_pos = 2'((3'd1 << shift) - 3'd1);
        lane     = raw_i & st_q.pc[0];
        pos      = raw_i ? st_q.pc[2:1] : st_q.pc[1:0];
        span_m1  = raw_i ? {last_pos, 1'b1} : {1'b0, last_pos};
        sum      = ((pos == 2'd0) ? '0 : st_q.acc[lane]) + ACC_W'(pix_i);

        st_d     = st_q;
        st_d.vld = 1'b0;
        if (!line_valid_i) begin
            st_d.pc = '0;
        end else if (en_i) begin
            st_d.acc[lane] = sum;
            if (pos == last_pos) begin
                st_d.vld = 1'b1;
                st_d.pix = DW'(sum >> shift);
            end
            st_d.pc = (st_q.pc == span_m1) ? '0 : st_q.pc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o = st_q.vld;
    assign pix_o = st_q.pix;

    // Without averaging each accepted pixel appears unchanged one clock later
    assert_pass_through_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !avg_code_i[0]) |=> (vld_o && pix_o == $past(pix_i)));

    // No result follows a cycle outside a row
    assert_no_stray_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !line_valid_i |=> !vld_o);

endmodule

// File: rtl/pix_decim.sv
module pix_decim
    import pdec_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start_i,
    input  logic          line_valid_i,
    input  logic [DW-1:0] pix_i,
    input  logic          raw_mode_i,
    input  logic [1:0]    skip_code_i,
    input  logic [1:0]    avg_code_i,
    output logic          line_valid_o,
    output logic          pix_valid_o,
    output logic [DW-1:0] pix_o
);

    typedef struct packed {
        logic lv;
    } top_state_t;

    top_state_t st_d, st_q;
    logic       keep;
    logic       pix_en;

    pdec_row_gate u_rows (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start_i(frame_start_i),
        .line_valid_i (line_valid_i),
        .raw_mode_i   (raw_mode_i),
        .skip_code_i  (skip_code_i),
        .keep_o       (keep)
    );

    assign pix_en = line_valid_i & keep;

    pdec_hsum #(.DW(DW)) u_avg (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_valid_i(line_valid_i),
        .en_i        (pix_en),
        .pix_i       (pix_i),
        .raw_i       (raw_mode_i),
        .avg_code_i  (avg_code_i),
        .vld_o       (pix_valid_o),
        .pix_o       (pix_o)
    );

    always_comb begin
        st_d    = st_q;
        st_d.lv = pix_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line_valid_o = st_q.lv;

    // A dropped row leaves both outputs low
    assert_drop_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid_i && !keep) |=> (!line_valid_o && !pix_valid_o));

    // Output strobes only inside the regenerated line
    assert_strobe_in_line_R13: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_o |-> line_valid_o);

    // Both outputs idle in the first cycle after reset
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!line_valid_o && !pix_valid_o));

endmodule

// File: tb/sim_pix_decim.sv
module sim_pix_decim;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start_i = 1'b0;
    logic          line_valid_i = 1'b0;
    logic [DW-1:0] pix_i = '0;
    logic          raw_mode_i = 1'b0;
    logic [1:0]    skip_code_i = 2'b00;
    logic [1:0]    avg_code_i = 2'b00;
    logic          line_valid_o;
    logic          pix_valid_o;
    logic [DW-1:0] pix_o;

    always #5 clk = ~clk;

    pix_decim #(.DW(DW)) u0 (.*);

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [DW-1:0] stim [64];
    logic [DW-1:0] got  [64];
    int            expv [64];
    int            got_n = 0;
    int            exp_n = 0;
    int            lvo_cnt = 0;

    // Row-skip table: [10]=raw, [9:8]=skip code, [7:0]=kept mask of rows 0..7
    localparam logic [10:0] ROWTAB [6] = '{
        {1'b0, 2'b00, 8'hFF},   // R2
        {1'b1, 2'b00, 8'hFF},   // R2
        {1'b0, 2'b01, 8'h55},   // R3
        {1'b1, 2'b01, 8'h33},   // R4
        {1'b0, 2'b10, 8'h11},   // R5
        {1'b1, 2'b11, 8'h03}    // R6
    };

    always @(negedge clk) begin
        if (rst_n) begin
            if (line_valid_o) lvo_cnt++;
            if (pix_valid_o && got_n < 64) begin
                got[got_n] = pix_o;
                got_n++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_cap();
        @(negedge clk);
        got_n = 0;
        lvo_cnt = 0;
    endtask

    task automatic frame_pulse();
        @(posedge clk); #1 frame_start_i = 1'b1;
        @(posedge clk); #1 frame_start_i = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic send_line(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1 line_valid_i = 1'b1; pix_i = stim[i];
        end
        @(posedge clk); #1 line_valid_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic model(input bit raw, input logic [1:0] code, input int n);
        int nn;
        int acc [2];
        nn = (code == 2'b01) ? 2 : (code == 2'b11) ? 4 : 1;
        exp_n = 0;
        acc[0] = 0; acc[1] = 0;
        for (int i = 0; i < n; i++) begin
            int lane;
            int pos;
            lane = raw ? (i % 2) : 0;
            pos  = raw ? ((i % (2 * nn)) / 2) : (i % nn);
            if (pos == 0) acc[lane] = 0;
            acc[lane] += int'(stim[i]);
            if (pos == nn - 1) begin
                expv[exp_n] = acc[lane] / nn;
                exp_n++;
            end
        end
    endtask

    task automatic run_avg(input bit raw, input logic [1:0] code, input int n, input string req);
        raw_mode_i = raw; avg_code_i = code; skip_code_i = 2'b00;
        frame_pulse();
        clear_cap();
        send_line(n);
        model(raw, code, n);
        chk(got_n == exp_n, {req, " count"}, got_n, exp_n);
        for (int k = 0; k < exp_n && k < got_n; k++)
            chk(int'(got[k]) == expv[k], {req, " value"}, int'(got[k]), expv[k]);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) stim[i] = DW'(i * 53 + 29);
        stim[0] = 8'd255; stim[1] = 8'd254;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!line_valid_o && !pix_valid_o, "R1 outputs in reset", int'(line_valid_o), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!line_valid_o && !pix_valid_o, "R1 outputs after reset", int'(pix_valid_o), 0);

        // Table walk: skip patterns (R2..R7)
        foreach (ROWTAB[t]) begin
            raw_mode_i  = ROWTAB[t][10];
            skip_code_i = ROWTAB[t][9:8];
            avg_code_i  = 2'b00;
            frame_pulse();
            for (int r = 0; r < 8; r++) begin
                int exp_cnt;
                clear_cap();
                send_line(4);
                exp_cnt = ROWTAB[t][r] ? 4 : 0;
                chk(lvo_cnt == exp_cnt, "R2-R6 row keep line_valid", lvo_cnt, exp_cnt);
                chk(got_n == exp_cnt, "R7 pixel strobes per row", got_n, exp_cnt);
            end
        end

        // R8: realign mid-frame; row 3 would be dropped, row 0 is kept
        raw_mode_i = 1'b0; skip_code_i = 2'b01; avg_code_i = 2'b00;
        frame_pulse();
        for (int r = 0; r < 3; r++) send_line(4);
        frame_pulse();
        clear_cap();
        send_line(4);
        chk(lvo_cnt == 4, "R8 row index reset", lvo_cnt, 4);

        // Averaging
        run_avg(1'b0, 2'b00, 5, "R9 no average");
        run_avg(1'b1, 2'b10, 5, "R9 no average code 10 raw");
        run_avg(1'b0, 2'b01, 8, "R10 pair mean");
        run_avg(1'b0, 2'b11, 8, "R10 quad mean");
        run_avg(1'b1, 2'b01, 8, "R11 raw pair");
        run_avg(1'b1, 2'b11, 16, "R11 raw quad");
        run_avg(1'b0, 2'b11, 10, "R12 partial quad");
        run_avg(1'b1, 2'b11, 7, "R12 raw partial");

        // R12: leftover from a short row does not leak into the next row
        raw_mode_i = 1'b0; avg_code_i = 2'b11; skip_code_i = 2'b00;
        frame_pulse();
        send_line(6);
        clear_cap();
        send_line(4);
        model(1'b0, 2'b11, 4);
        chk(got_n == 1, "R12 next row count", got_n, 1);
        chk(int'(got[0]) == expv[0], "R12 next row value", int'(got[0]), expv[0]);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errs++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule